// File: doc/BRIEF.md
# Endian-Aware Atomic Memory ALU

This block performs the read-modify-write arithmetic for atomic memory operations at the memory side of the bus. Each atomic operation arrives as one bus transaction. The transaction carries an opcode, an operand size, the register operand, and a flag that gives the data byte order. The issuing core sets this flag from its current data-endianness mode. The block also receives the 64-bit beat read from memory. It returns two values: the beat to write back to memory, and the old memory value converted into the core's byte order.

The arithmetic always works on little-endian values. When the transaction is marked big-endian, the memory value is byte-reversed within the operand size before it enters the arithmetic unit. The result is reversed again on the way back to memory. The register operand is already in core order and is never reversed. A 32-bit operation uses only the addressed word of the beat and passes the other word through untouched. Results appear one cycle after the request.

Top module: `amo_endian_alu`

## Requirements
- R1: With the flag clear and a 64-bit size, the written beat is f(old, operand), where f is selected by `amo_op`: 0 swap (operand), 1 add (modulo 2^XLEN), 2 and, 3 or, 4 xor, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max.
- R2: Codes 5 and 6 compare two's-complement values, and codes 7 and 8 compare unsigned values. For 32-bit operations the comparison uses bit 31 as the sign.
- R3: When `size_dw`=0, the operation acts on the word chosen by `word_sel` (0 = beat bytes 0..3, 1 = beat bytes 4..7), and the other word of the written beat equals the same word of `mem_rdata`.
- R4: For a 32-bit operation, `core_rdata` is the old word in core order, sign-extended from bit 31 to 64 bits. For a 64-bit operation it is the whole old value in core order.
- R5: With `be_mode`=0, no byte is reordered: `core_rdata` equals `mem_rdata` for 64-bit operations, and the result is written in the byte order it was computed in.
- R6: With `be_mode`=1, the memory value is byte-reversed within the operand size (4 or 8 bytes) before the arithmetic, and the result is byte-reversed within the same size before it is written.
- R7: With `be_mode`=1, min and max compare the byte-reversed values, not the raw memory bytes.
- R8: Opcodes 9 to 15 write back the memory beat unchanged and still return the old value.
- R9: `out_valid` is `in_valid` delayed by one clock. `mem_wdata` and `core_rdata` change only one cycle after an accepted request and otherwise hold their values.
- R10: While `rst_n` is low, `out_valid`, `mem_wdata` and `core_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| amo_op | input | 4 | Operation code (see R1, R8) |
| size_dw | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| word_sel | input | 1 | Word of the beat used by a 32-bit operation |
| be_mode | input | 1 | Transaction endianness flag, 1 = big-endian |
| operand | input | XLEN | Register operand in core order |
| mem_rdata | input | XLEN | Beat read from memory |
| out_valid | output | 1 | Result present |
| mem_wdata | output | XLEN | Beat to write back to memory |
| core_rdata | output | XLEN | Old value in core order |

## Verification
The bench builds the block with its defaults: XLEN=64 and a registered output stage. These settings let it reach both operand sizes, both word lanes, and the one-cycle latency and hold behaviour. The 32-bit width and the combinational output variant are elaborated only; the bench does not run them. Random requests cover all sixteen opcode values in both byte orders. Directed cases pick memory bytes whose sign flips under reversal, so that raw-byte comparisons and reversed-value comparisons give different answers.

// File: rtl/amo_endian_pkg.sv
package amo_endian_pkg;

   typedef enum logic [3:0] {
      AMO_SWAP = 4'd0,
      AMO_ADD  = 4'd1,
      AMO_AND  = 4'd2,
      AMO_OR   = 4'd3,
      AMO_XOR  = 4'd4,
      AMO_MIN  = 4'd5,
      AMO_MAX  = 4'd6,
      AMO_MINU = 4'd7,
      AMO_MAXU = 4'd8
   } amo_op_e;

   localparam int unsigned WORD_W = 32;

   // Reverse the byte order of a 32-bit word.
   function automatic logic [WORD_W-1:0] flip32(input logic [WORD_W-1:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

endpackage

// File: rtl/amo_byte_swap.sv
module amo_byte_swap #(
   parameter int unsigned W = 32
) (
   input  logic         en_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   localparam int unsigned NB = W / 8;

   if ((W % 8) != 0 || W == 0) begin : g_bad_w
      $error("amo_byte_swap: W must be a non-zero multiple of 8");
   end

   logic [W-1:0] rev;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign rev[8*i +: 8] = din_i[8*(NB-1-i) +: 8];
   end

   assign dout_o = en_i ? rev : din_i;
endmodule

// File: rtl/amo_load_conv.sv
module amo_load_conv #(
   parameter int unsigned XLEN = 64
) (
   input  logic            be_i,
   input  logic            dw_i,
   input  logic            sel_i,
   input  logic [XLEN-1:0] rdata_i,
   output logic [31:0]     word_o,
   output logic [XLEN-1:0] full_o
);
   if (XLEN == 64) begin : g_x64
      logic [31:0] lo_c, hi_c;

      amo_byte_swap #(.W(32)) u_sw_lo (
         .en_i  (be_i),
         .din_i (rdata_i[31:0]),
         .dout_o(lo_c)
      );
      amo_byte_swap #(.W(32)) u_sw_hi (
         .en_i  (be_i),
         .din_i (rdata_i[63:32]),
         .dout_o(hi_c)
      );

      // A full 8-byte reversal is the two word reversals with the words exchanged.
      assign word_o = sel_i ? hi_c : lo_c;
      assign full_o = (be_i && dw_i) ? {lo_c, hi_c} : rdata_i;
   end else begin : g_x32
      logic [31:0] w_c;
      logic        unused_ok;

      amo_byte_swap #(.W(32)) u_sw (
         .en_i  (be_i),
         .din_i (rdata_i),
         .dout_o(w_c)
      );

      assign word_o    = w_c;
      assign full_o    = w_c;
      assign unused_ok = dw_i ^ sel_i;
   end
endmodule

// File: rtl/amo_arith.sv
module amo_arith
   import amo_endian_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [3:0]      op_i,
   input  logic            dw_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] res_o
);
   localparam int unsigned HW = XLEN - 32;

   amo_op_e     op;
   logic        signed_cmp;
   logic [XLEN-1:0] ax, bx;
   logic        lt_s, lt_u;

   assign op         = amo_op_e'(op_i);
   assign signed_cmp = (op == AMO_MIN) || (op == AMO_MAX);

   if (XLEN > 32) begin : g_ext
      // Narrow operands are widened so that one full-width comparator serves both sizes.
      always_comb begin
         if (dw_i) begin
            ax = a_i;
            bx = b_i;
         end else if (signed_cmp) begin
            ax = {{HW{a_i[31]}}, a_i[31:0]};
            bx = {{HW{b_i[31]}}, b_i[31:0]};
         end else begin
            ax = {{HW{1'b0}}, a_i[31:0]};
            bx = {{HW{1'b0}}, b_i[31:0]};
         end
      end
   end else begin : g_noext
      logic unused_ok;
      assign ax        = a_i;
      assign bx        = b_i;
      assign unused_ok = dw_i;
   end

   assign lt_s = $signed(ax) < $signed(bx);
   assign lt_u = ax < bx;

   always_comb begin
      case (op)
         AMO_SWAP: res_o = bx;
         AMO_ADD:  res_o = ax + bx;
         AMO_AND:  res_o = ax & bx;
         AMO_OR:   res_o = ax | bx;
         AMO_XOR:  res_o = ax ^ bx;
         AMO_MIN:  res_o = lt_s ? ax : bx;
         AMO_MAX:  res_o = lt_s ? bx : ax;
         AMO_MINU: res_o = lt_u ? ax : bx;
         AMO_MAXU: res_o = lt_u ? bx : ax;
         default:  res_o = ax;
      endcase
   end
endmodule

// File: rtl/amo_store_merge.sv
module amo_store_merge #(
   parameter int unsigned XLEN = 64
) (
   input  logic            be_i,
   input  logic            dw_i,
   input  logic            sel_i,
   input  logic [XLEN-1:0] res_i,
   input  logic [XLEN-1:0] rdata_i,
   output logic [XLEN-1:0] wdata_o
);
   if (XLEN == 64) begin : g_x64
      logic [31:0] lo_s, hi_s;

      amo_byte_swap #(.W(32)) u_sw_lo (
         .en_i  (be_i),
         .din_i (res_i[31:0]),
         .dout_o(lo_s)
      );
      amo_byte_swap #(.W(32)) u_sw_hi (
         .en_i  (be_i),
         .din_i (res_i[63:32]),
         .dout_o(hi_s)
      );

      always_comb begin
         if (dw_i) begin
            wdata_o = be_i ? {lo_s, hi_s} : res_i;
         end else if (sel_i) begin
            wdata_o = {lo_s, rdata_i[31:0]};
         end else begin
            wdata_o = {rdata_i[63:32], lo_s};
         end
      end
   end else begin : g_x32
      logic unused_ok;

      amo_byte_swap #(.W(32)) u_sw (
         .en_i  (be_i),
         .din_i (res_i),
         .dout_o(wdata_o)
      );

      assign unused_ok = dw_i ^ sel_i ^ (^rdata_i);
   end
endmodule

// File: rtl/amo_endian_alu.sv
module amo_endian_alu #(
   parameter int unsigned XLEN    = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [3:0]      amo_op,
   input  logic            size_dw,
   input  logic            word_sel,
   input  logic            be_mode,
   input  logic [XLEN-1:0] operand,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            out_valid,
   output logic [XLEN-1:0] mem_wdata,
   output logic [XLEN-1:0] core_rdata
);
   localparam int unsigned HW = XLEN - 32;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("amo_endian_alu: XLEN must be 32 or 64");
   end

   logic            dw_eff;
   logic [31:0]     old_word;
   logic [XLEN-1:0] old_full;
   logic [XLEN-1:0] alu_a;
   logic [XLEN-1:0] alu_res;
   logic [XLEN-1:0] ret_c;
   logic [XLEN-1:0] wdata_c;

   assign dw_eff = (XLEN == 64) && size_dw;

   amo_load_conv #(.XLEN(XLEN)) u_load (
      .be_i   (be_mode),
      .dw_i   (dw_eff),
      .sel_i  (word_sel),
      .rdata_i(mem_rdata),
      .word_o (old_word),
      .full_o (old_full)
   );

   if (XLEN > 32) begin : g_wide
      assign alu_a = dw_eff ? old_full : {{HW{1'b0}}, old_word};
      assign ret_c = dw_eff ? old_full : {{HW{old_word[31]}}, old_word};
   end else begin : g_narrow
      assign alu_a = old_word;
      assign ret_c = old_word;
   end

   amo_arith #(.XLEN(XLEN)) u_arith (
      .op_i (amo_op),
      .dw_i (dw_eff),
      .a_i  (alu_a),
      .b_i  (operand),
      .res_o(alu_res)
   );

   amo_store_merge #(.XLEN(XLEN)) u_store (
      .be_i   (be_mode),
      .dw_i   (dw_eff),
      .sel_i  (word_sel),
      .res_i  (alu_res),
      .rdata_i(mem_rdata),
      .wdata_o(wdata_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            mem_wdata  <= '0;
            core_rdata <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               mem_wdata  <= wdata_c;
               core_rdata <= ret_c;
            end
         end
      end
   end else begin : g_comb
      logic unused_ok;
      assign out_valid  = in_valid;
      assign mem_wdata  = wdata_c;
      assign core_rdata = ret_c;
      assign unused_ok  = clk ^ rst_n;
   end
endmodule

// File: rtl/amo_endian_alu_chk.sv
module amo_endian_alu_chk #(
   parameter int unsigned XLEN    = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [3:0]      amo_op,
   input logic            size_dw,
   input logic            word_sel,
   input logic            be_mode,
   input logic [XLEN-1:0] operand,
   input logic [XLEN-1:0] mem_rdata,
   input logic            out_valid,
   input logic [XLEN-1:0] mem_wdata,
   input logic [XLEN-1:0] core_rdata
);
   if (REG_OUT) begin : g_reg_chk
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> out_valid == $past(in_valid)); // R9
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(in_valid)) |-> ($stable(mem_wdata) && $stable(core_rdata))); // R9
      AST_UNDEF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(in_valid) && $past(amo_op) > 4'd8) |-> mem_wdata == $past(mem_rdata)); // R8
      AST_LE_RET: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(in_valid) && !$past(be_mode) && ($past(size_dw) || XLEN == 32))
         |-> core_rdata == $past(mem_rdata)); // R5
      AST_LE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(in_valid) && !$past(be_mode) && $past(amo_op) == 4'd0
          && ($past(size_dw) || XLEN == 32))
         |-> mem_wdata == $past(operand)); // R1
      if (XLEN == 64) begin : g_half
         AST_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && !$past(size_dw) && $past(word_sel))
            |-> mem_wdata[31:0] == $past(mem_rdata[31:0])); // R3
         AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && !$past(size_dw) && !$past(word_sel))
            |-> mem_wdata[63:32] == $past(mem_rdata[63:32])); // R3
         AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && !$past(size_dw))
            |-> core_rdata[63:32] == {32{core_rdata[31]}}); // R4
      end
   end else begin : g_comb_chk
      always_comb begin
         if (rst_n && in_valid && amo_op > 4'd8) begin
            AST_UNDEF_KEEP_C: assert (mem_wdata == mem_rdata); // R8
         end
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      (REG_OUT && $past(!rst_n) && !rst_n) |-> !out_valid); // R10
endmodule

bind amo_endian_alu amo_endian_alu_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .amo_op    (amo_op),
   .size_dw   (size_dw),
   .word_sel  (word_sel),
   .be_mode   (be_mode),
   .operand   (operand),
   .mem_rdata (mem_rdata),
   .out_valid (out_valid),
   .mem_wdata (mem_wdata),
   .core_rdata(core_rdata)
);

// File: tb/amo_endian_alu_bench.sv
module amo_endian_alu_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  amo_op = '0;
   logic        size_dw = 1'b0;
   logic        word_sel = 1'b0;
   logic        be_mode = 1'b0;
   logic [63:0] operand = '0;
   logic [63:0] mem_rdata = '0;
   logic        out_valid;
   logic [63:0] mem_wdata;
   logic [63:0] core_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   amo_endian_alu u_amo_endian_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .amo_op(amo_op),
      .size_dw(size_dw), .word_sel(word_sel), .be_mode(be_mode),
      .operand(operand), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .mem_wdata(mem_wdata), .core_rdata(core_rdata)
   );

   function automatic logic [63:0] rev_bytes(input logic [63:0] v, input int nb);
      logic [63:0] r = '0;
      for (int i = 0; i < nb; i++) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
      return r;
   endfunction

   function automatic void model(input logic [3:0] op, input bit dw, input bit sel, input bit be,
                                 input logic [63:0] opnd, input logic [63:0] rd,
                                 output logic [63:0] wr, output logic [63:0] ret);
      int nb = dw ? 8 : 4;
      logic [63:0] a, b, r, mask;
      bit lt_s, lt_u;
      mask = dw ? '1 : 64'h0000_0000_FFFF_FFFF;
      a = dw ? rd : (sel ? {32'b0, rd[63:32]} : {32'b0, rd[31:0]});
      if (be) a = rev_bytes(a, nb);
      b = opnd & mask;
      lt_u = a < b;
      if (dw) lt_s = $signed(a) < $signed(b);
      else    lt_s = $signed(a[31:0]) < $signed(b[31:0]);
      case (op)
         4'd0: r = b;
         4'd1: r = a + b;
         4'd2: r = a & b;
         4'd3: r = a | b;
         4'd4: r = a ^ b;
         4'd5: r = lt_s ? a : b;
         4'd6: r = lt_s ? b : a;
         4'd7: r = lt_u ? a : b;
         4'd8: r = lt_u ? b : a;
         default: r = a;
      endcase
      r = r & mask;
      if (be) r = rev_bytes(r, nb);
      if (dw)       wr = r;
      else if (sel) wr = {r[31:0], rd[31:0]};
      else          wr = {rd[63:32], r[31:0]};
      ret = dw ? a : {{32{a[31]}}, a[31:0]};
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Called at a falling edge: drive, wait one cycle, compare.
   task automatic run_op(input string req, input logic [3:0] op, input bit dw, input bit sel,
                         input bit be, input logic [63:0] opnd, input logic [63:0] rd);
      logic [63:0] ew, er;
      in_valid = 1'b1; amo_op = op; size_dw = dw; word_sel = sel; be_mode = be;
      operand = opnd; mem_rdata = rd;
      model(op, dw, sel, be, opnd, rd, ew, er);
      @(negedge clk);
      check("R9", "out_valid", {63'b0, out_valid}, 64'd1);
      check(req, "mem_wdata", mem_wdata, ew);
      check(req, "core_rdata", core_rdata, er);
   endtask

   task automatic idle_check();
      logic [63:0] pw, pr;
      pw = mem_wdata; pr = core_rdata;
      in_valid = 1'b0; amo_op = 4'($urandom); size_dw = 1'($urandom); be_mode = 1'($urandom);
      operand = {$urandom, $urandom}; mem_rdata = {$urandom, $urandom};
      @(negedge clk);
      check("R9", "idle out_valid", {63'b0, out_valid}, 64'd0);
      check("R9", "idle mem_wdata", mem_wdata, pw);
      check("R9", "idle core_rdata", core_rdata, pr);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      in_valid = 1'b1;
      operand = 64'hDEAD_BEEF_0000_0001;
      mem_rdata = 64'h1234;
      repeat (3) @(negedge clk);
      // R10: reset holds outputs at zero even with a request applied
      check("R10", "reset out_valid", {63'b0, out_valid}, 64'd0);
      check("R10", "reset mem_wdata", mem_wdata, 64'd0);
      check("R10", "reset core_rdata", core_rdata, 64'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R6: 32-bit add, big-endian, low word
      run_op("R6", 4'd1, 1'b0, 1'b0, 1'b1, 64'd1, 64'hAAAA_BBBB_1122_3344);
      check("R6", "be add32 literal", mem_wdata, 64'hAAAA_BBBB_1222_3344);
      check("R4", "be add32 return", core_rdata, 64'h0000_0000_4433_2211);
      // R6: 64-bit add, big-endian
      run_op("R6", 4'd1, 1'b1, 1'b0, 1'b1, 64'hFF, 64'h0100_0000_0000_0000);
      check("R6", "be add64 literal", mem_wdata, 64'h0001_0000_0000_0000);
      // R7 / R2: sign flips under reversal
      run_op("R7", 4'd5, 1'b0, 1'b0, 1'b1, 64'd1, 64'h0000_0000_0000_00FF);
      check("R7", "be min32 signed", mem_wdata, 64'h0000_0000_0000_00FF);
      check("R4", "be min32 sext", core_rdata, 64'hFFFF_FFFF_FF00_0000);
      run_op("R7", 4'd7, 1'b0, 1'b0, 1'b1, 64'd1, 64'h0000_0000_0000_00FF);
      check("R7", "be minu32", mem_wdata, 64'h0000_0000_0100_0000);
      run_op("R2", 4'd5, 1'b0, 1'b0, 1'b0, 64'd1, 64'h0000_0000_0000_00FF);
      check("R2", "le min32", mem_wdata, 64'h0000_0000_0000_0001);
      run_op("R2", 4'd6, 1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd5);
      check("R2", "le max64 signed", mem_wdata, 64'd5);
      // R3: upper word, little-endian xor
      run_op("R3", 4'd4, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_0F0F_0F0F, 64'h1234_5678_9ABC_DEF0);
      check("R3", "le xor32 hi", mem_wdata, 64'h1D3B_5977_9ABC_DEF0);
      // R5: little-endian 64-bit swap leaves bytes in order
      run_op("R5", 4'd0, 1'b1, 1'b0, 1'b0, 64'h0102_0304_0506_0708, 64'h1122_3344_5566_7788);
      check("R5", "le ret64", core_rdata, 64'h1122_3344_5566_7788);
      // R8: undefined opcode
      run_op("R8", 4'd12, 1'b1, 1'b0, 1'b1, 64'h5555, 64'h0123_4567_89AB_CDEF);
      check("R8", "undef keep", mem_wdata, 64'h0123_4567_89AB_CDEF);
      idle_check();

      for (int n = 0; n < 600; n++) begin
         logic [3:0]  op;
         bit          dw, sel, be;
         logic [63:0] opnd, rd;
         string       tag;
         op   = 4'($urandom % 16);
         dw   = 1'($urandom);
         sel  = 1'($urandom);
         be   = 1'($urandom);
         opnd = {$urandom, $urandom};
         rd   = {$urandom, $urandom};
         if (($urandom % 8) == 0) rd = be ? rev_bytes(opnd, 8) : opnd;
         if (op > 4'd8)           tag = "R8";
         else if (be)             tag = (op >= 4'd5) ? "R7" : "R6";
         else if (!dw)            tag = "R3";
         else                     tag = (op >= 4'd5) ? "R2" : "R1";
         run_op(tag, op, dw, sel, be, opnd, rd);
         if (($urandom % 5) == 0) idle_check();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule